// File: doc/BRIEF.md
# I2C Real-Time-Clock Register Access Engine

This block is the byte-level slave front end of a real-time-clock device. An I2C byte engine in front of it has already decoded the serial bus. It reports each bus event with a one-cycle strobe: a START addressed for writing, a START addressed for reading, a STOP, a received byte, or a request for the next byte to transmit. The engine keeps a 16-byte register window and a register pointer that advances after every data byte.

The first byte written after a write START is an address byte, not data. Its upper nibble selects the register and its lower nibble is kept as a transfer-format code. On a read START, the live time from the timekeeper is frozen into shadow registers 0 to 6 and the pointer is set to the last register. A read therefore returns the control byte first and then the time fields in order. Data written to registers 0 to 6 is masked and converted into a timekeeper update, except for the weekday, which becomes a stored offset. Data written to registers 7 to 15 is kept locally. Register 15 bit 5 selects 24-hour (1) or 12-hour (0) presentation of the hour.

Top module: `rtc_reg_engine`

## Requirements
- R1: The window holds 16 bytes. The 4-bit pointer advances by one, modulo 16, after every data byte read or written, so register 15 is followed by register 0.
- R2: The first byte after a write START loads the pointer from bits 7:4 and `fmt_o` from bits 3:0. It is not stored and it causes no timekeeper update.
- R3: A read START copies seconds, minutes, hour, weekday, day of month, month and year into registers 0..6 and sets the pointer to 15. The reads that follow return register 15 and then registers 0, 1, 2 and onward.
- R4: A data byte written at pointer 0, 1, 2, 4, 5 or 6 pulses `tk_wr_o` for one cycle on the next clock edge, with `tk_sel_o` equal to the pointer. A data byte written at pointer 7..15 is stored and reads back unchanged.
- R5: Timekeeper data is masked: 0x7F for seconds and minutes, 0x3F for day of month and for the hour in 24-hour mode, 0x1F for month, and no mask for year.
- R6: The hour snapshot is the live 24-hour BCD value when register 15 bit 5 is 1. When the bit is 0 it is a 12-hour value: hours 0 and 12 map to 12, and bit 5 is set for hours 12..23.
- R7: In 12-hour mode a written hour byte (bits 4:0 BCD 1..12, bit 5 PM) reaches the timekeeper as 24-hour BCD, where 12 AM is 0 and 12 PM is 12.
- R8: A write at pointer 3 raises no `tk_wr_o`. It stores a weekday offset such that a later snapshot reports ((u+6+d) mod 7)+1, where u is data bits 2:0 and d is the live weekday (0..6) at snapshot time minus the live weekday at the write, modulo 7.
- R9: Reset clears all 16 registers, the pointer, the address-pending flag, `fmt_o`, the timekeeper strobe and the weekday offset.
- R10: `rd_valid_o` follows `rd_req_i` in the same cycle, and `rd_data_o` is then the register at the pointer. A read request with no read START returns the register at the current pointer.
- R11: A STOP cancels a pending address byte, so the next byte is treated as data at the current pointer.
- R12: `dev_addr_o` gives the 7-bit slave address parameter, 0x32 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_wr_i | input | 1 | Write START strobe |
| start_rd_i | input | 1 | Read START strobe |
| stop_i | input | 1 | STOP strobe |
| wr_byte_i | input | 1 | Received-byte strobe |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Byte-to-transmit request strobe |
| rd_data_o | output | 8 | Register at pointer (combinational) |
| rd_valid_o | output | 1 | Read data valid |
| fmt_o | output | 4 | Latched transfer-format code |
| live_sec_i | input | 8 | Live seconds, BCD |
| live_min_i | input | 8 | Live minutes, BCD |
| live_hour_i | input | 8 | Live hour, 24-hour BCD |
| live_wday_i | input | 3 | Live weekday index 0..6 |
| live_mday_i | input | 8 | Live day of month, BCD |
| live_mon_i | input | 8 | Live month, BCD |
| live_year_i | input | 8 | Live year, BCD |
| tk_wr_o | output | 1 | Timekeeper update strobe |
| tk_sel_o | output | 3 | Time field being updated |
| tk_data_o | output | 8 | Masked / converted field value |
| dev_addr_o | output | 7 | Slave address |

## Verification
Read data and `rd_valid_o` are combinational, so the bench samples them 1 ns after raising `rd_req_i`, before the edge that advances the pointer. Each timekeeper update is registered once and appears after the clock edge that takes the data byte. The bench samples it at the following falling edge, where it also checks that no update appears for address and weekday bytes. A snapshot and the forced pointer take effect on the edge that takes the read START, so the bench issues its reads from the next cycle on. The sweeps cover all 24 hours in both modes, all 24 12-hour write codes, every weekday setting against every live weekday, and every stored register including the wrap from 15 to 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_NUM    = 16;
  localparam int PTR_W      = $clog2(REG_NUM);
  localparam int TIME_NUM   = 7;
  localparam int SEL_W      = $clog2(TIME_NUM);
  localparam int HOUR_IDX   = 2;
  localparam int WDAY_IDX   = 3;
  localparam int HOUR24_BIT = 5;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  // 0..20 folded to 0..6
  function automatic logic [2:0] mod7(input logic [4:0] s);
    if (s >= 5'd14) return 3'(s - 5'd14);
    else if (s >= 5'd7) return 3'(s - 5'd7);
    else return 3'(s);
  endfunction

  function automatic logic [7:0] hour24_to_12(input logic [7:0] h);
    logic [6:0] b;
    b = bcd2bin(h);
    if (b == 7'd0) return 8'h12;
    else if (b < 7'd12) return bin2bcd(b);
    else if (b == 7'd12) return 8'h32;
    else return 8'h20 | bin2bcd(b - 7'd12);
  endfunction

  function automatic logic [7:0] hour12_to_24(input logic [7:0] d);
    logic [6:0] b;
    b = bcd2bin({3'b000, d[4:0]});
    if (d[HOUR24_BIT]) b = b + 7'd12;
    if (b == 7'd12 || b == 7'd24) b = b - 7'd12;
    return bin2bcd(b);
  endfunction
endpackage

// File: rtl/rtc_ptr_ctrl.sv
module rtc_ptr_ctrl
  import rtc_pkg::*;
#(
  parameter int PW = PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_wr_i,
  input  logic          start_rd_i,
  input  logic          stop_i,
  input  logic          wr_byte_i,
  input  logic          rd_req_i,
  input  logic [7:0]    wr_data_i,
  output logic [PW-1:0] ptr_o,
  output logic          addr_pend_o,
  output logic [3:0]    fmt_o
);
  logic [PW-1:0] ptr_q;
  logic          pend_q;
  logic [3:0]    fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      fmt_q  <= '0;
    end else if (start_rd_i) begin
      ptr_q  <= '1;
      pend_q <= 1'b0;
    end else if (start_wr_i) begin
      pend_q <= 1'b1;
    end else if (stop_i) begin
      pend_q <= 1'b0;
    end else if (wr_byte_i) begin
      if (pend_q) begin
        ptr_q  <= wr_data_i[7 -: PW];
        fmt_q  <= wr_data_i[3:0];
        pend_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + PW'(1);
      end
    end else if (rd_req_i) begin
      ptr_q <= ptr_q + PW'(1);
    end
  end

  assign ptr_o       = ptr_q;
  assign addr_pend_o = pend_q;
  assign fmt_o       = fmt_q;

  assert_rd_start_ptr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_i |=> ptr_o == '1);
  assert_ptr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !start_rd_i && !start_wr_i && !stop_i && !wr_byte_i)
      |=> ptr_o == $past(ptr_o) + PW'(1));
  assert_stop_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_rd_i && !start_wr_i) |=> !addr_pend_o);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int N  = REG_NUM,
  parameter int TN = TIME_NUM,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snap_i,
  input  logic [TN*8-1:0] snap_bus_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    ctrl_o
);
  logic [N*8-1:0] regs_flat;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [7:0] q;
    if (i < TN) begin : g_shadow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (snap_i) q <= snap_bus_i[i*8 +: 8];
      end
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && waddr_i == AW'(i)) q <= wdata_i;
      end
    end
    assign regs_flat[i*8 +: 8] = q;
  end

  assign rdata_o = regs_flat[raddr_i*8 +: 8];
  assign ctrl_o  = regs_flat[(N-1)*8 +: 8];

  assert_store_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !snap_i) |-> waddr_i >= AW'(TN));
endmodule

// File: rtl/rtc_wday_track.sv
module rtc_wday_track
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [2:0] user_i,
  input  logic [2:0] live_i,
  output logic [2:0] wday_o
);
  logic [2:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else if (set_i) off_q <= mod7(5'(user_i) + 5'd13 - 5'(live_i));
  end

  assign wday_o = mod7(5'(live_i) + 5'(off_q)) + 3'd1;

  assert_wday_off_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q < 3'd7);
  assert_wday_out_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i < 3'd7) |-> (wday_o != 3'd0));
endmodule

// File: rtl/rtc_time_wr.sv
module rtc_time_wr
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       data_i,
  input  logic             mode24_i,
  output logic             tk_wr_o,
  output logic [SEL_W-1:0] tk_sel_o,
  output logic [7:0]       tk_data_o
);
  logic [7:0] masked;

  always_comb begin
    unique case (sel_i)
      3'd0, 3'd1: masked = data_i & 8'h7F;
      3'd2:       masked = mode24_i ? (data_i & 8'h3F) : hour12_to_24(data_i);
      3'd4:       masked = data_i & 8'h3F;
      3'd5:       masked = data_i & 8'h1F;
      default:    masked = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_wr_o   <= 1'b0;
      tk_sel_o  <= '0;
      tk_data_o <= '0;
    end else begin
      tk_wr_o <= en_i;
      if (en_i) begin
        tk_sel_o  <= sel_i;
        tk_data_o <= masked;
      end
    end
  end

  assert_tk_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_wr_o |-> (tk_sel_o < SEL_W'(TIME_NUM) && tk_sel_o != SEL_W'(WDAY_IDX)));
  assert_sec_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk_wr_o && tk_sel_o < SEL_W'(2)) |-> !tk_data_o[7]);
  assert_mon_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk_wr_o && tk_sel_o == SEL_W'(5)) |-> tk_data_o[7:5] == 3'b000);
endmodule

// File: rtl/rtc_reg_engine.sv
module rtc_reg_engine
  import rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_wr_i,
  input  logic       start_rd_i,
  input  logic       stop_i,
  input  logic       wr_byte_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_req_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  output logic [3:0] fmt_o,
  input  logic [7:0] live_sec_i,
  input  logic [7:0] live_min_i,
  input  logic [7:0] live_hour_i,
  input  logic [2:0] live_wday_i,
  input  logic [7:0] live_mday_i,
  input  logic [7:0] live_mon_i,
  input  logic [7:0] live_year_i,
  output logic       tk_wr_o,
  output logic [2:0] tk_sel_o,
  output logic [7:0] tk_data_o,
  output logic [6:0] dev_addr_o
);
  logic [PTR_W-1:0] ptr;
  logic             addr_pend;
  logic             data_wr;
  logic             time_wr;
  logic             wday_set;
  logic             reg_we;
  logic [7:0]       ctrl;
  logic [2:0]       wday_now;
  logic [7:0]       hour_snap;
  logic [TIME_NUM*8-1:0] snap_bus;

  rtc_ptr_ctrl u_ptr (
    .clk_i, .rst_ni, .start_wr_i, .start_rd_i, .stop_i, .wr_byte_i, .rd_req_i,
    .wr_data_i, .ptr_o(ptr), .addr_pend_o(addr_pend), .fmt_o
  );

  assign data_wr  = wr_byte_i && !addr_pend && !start_rd_i && !start_wr_i && !stop_i;
  assign time_wr  = data_wr && ptr < PTR_W'(TIME_NUM) && ptr != PTR_W'(WDAY_IDX);
  assign wday_set = data_wr && ptr == PTR_W'(WDAY_IDX);
  assign reg_we   = data_wr && ptr >= PTR_W'(TIME_NUM);

  rtc_wday_track u_wday (
    .clk_i, .rst_ni, .set_i(wday_set), .user_i(wr_data_i[2:0]),
    .live_i(live_wday_i), .wday_o(wday_now)
  );

  assign hour_snap = ctrl[HOUR24_BIT] ? live_hour_i : hour24_to_12(live_hour_i);
  assign snap_bus  = {live_year_i, live_mon_i, live_mday_i, {5'b0, wday_now},
                      hour_snap, live_min_i, live_sec_i};

  rtc_regfile u_regs (
    .clk_i, .rst_ni, .snap_i(start_rd_i), .snap_bus_i(snap_bus),
    .we_i(reg_we), .waddr_i(ptr), .wdata_i(wr_data_i), .raddr_i(ptr),
    .rdata_o(rd_data_o), .ctrl_o(ctrl)
  );

  rtc_time_wr u_twr (
    .clk_i, .rst_ni, .en_i(time_wr), .sel_i(ptr[SEL_W-1:0]), .data_i(wr_data_i),
    .mode24_i(ctrl[HOUR24_BIT]), .tk_wr_o, .tk_sel_o, .tk_data_o
  );

  assign rd_valid_o = rd_req_i;
  assign dev_addr_o = DEV_ADDR;

  assert_addr_no_tk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && addr_pend && !start_rd_i && !start_wr_i && !stop_i) |=> !tk_wr_o);
  assert_hour_pm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tk_wr_o && tk_sel_o == 3'd2) |-> tk_data_o[7:6] == 2'b00);
endmodule

// File: tb/rtc_reg_engine_tb.sv
`timescale 1ns/1ps
module rtc_reg_engine_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_wr = 0, start_rd = 0, stop = 0, wr_byte = 0, rd_req = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [3:0] fmt;
  logic [7:0] l_sec = 8'h00, l_min = 8'h00, l_hour = 8'h00, l_mday = 8'h01, l_mon = 8'h01, l_year = 8'h00;
  logic [2:0] l_wday = 3'd0;
  logic tk_wr;
  logic [2:0] tk_sel;
  logic [7:0] tk_data;
  logic [6:0] dev_addr;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rv;
  logic s_wr;
  logic [2:0] s_sel;
  logic [7:0] s_data;

  always #2.5 clk = ~clk;

  rtc_reg_engine u_dut (
    .clk_i(clk), .rst_ni, .start_wr_i(start_wr), .start_rd_i(start_rd), .stop_i(stop),
    .wr_byte_i(wr_byte), .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .fmt_o(fmt), .live_sec_i(l_sec), .live_min_i(l_min),
    .live_hour_i(l_hour), .live_wday_i(l_wday), .live_mday_i(l_mday), .live_mon_i(l_mon),
    .live_year_i(l_year), .tk_wr_o(tk_wr), .tk_sel_o(tk_sel), .tk_data_o(tk_data),
    .dev_addr_o(dev_addr)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic p_start_wr; start_wr = 1; @(negedge clk); start_wr = 0; endtask
  task automatic p_start_rd; start_rd = 1; @(negedge clk); start_rd = 0; endtask
  task automatic p_stop;     stop = 1;     @(negedge clk); stop = 0;     endtask

  task automatic p_wr(input logic [7:0] d);
    wr_byte = 1; wr_data = d;
    @(negedge clk);
    wr_byte = 0;
    s_wr = tk_wr; s_sel = tk_sel; s_data = tk_data;
  endtask

  task automatic p_rd(output logic [7:0] v);
    rd_req = 1;
    #1;
    v = rd_data;
    chk("R10 rd_valid high", int'(rd_valid), 1);
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic set_reg(input logic [7:0] a, input logic [7:0] d);
    p_start_wr; p_wr({a[3:0], 4'h0}); p_wr(d); p_stop;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state
    chk("R9 tk_wr after reset", int'(tk_wr), 0);
    chk("R9 fmt after reset", int'(fmt), 0);
    chk("R10 rd_valid idle", int'(rd_valid), 0);
    chk("R12 dev addr", int'(dev_addr), 'h32);
    p_rd(rv); chk("R9 reg0 after reset", rv, 0);
    p_rd(rv); chk("R9 reg1 after reset (R1 ptr step)", rv, 0);
    chk("R10 rd_valid drops", int'(rd_valid), 0);

    // address byte: pointer+format, not stored, no update
    p_start_wr; p_wr(8'h7A);
    chk("R2 no tk on addr byte", int'(s_wr), 0);
    chk("R2 fmt nibble", int'(fmt), 'hA);
    p_rd(rv); chk("R2 addr byte not stored at reg7", rv, 0);
    p_stop;

    // burst write 7..15 then wrap to 0
    p_start_wr; p_wr(8'h70);
    for (int p = 7; p < 16; p++) begin
      p_wr(8'((p * 17) ^ 'h5A));
      chk("R4 no tk for stored reg", int'(s_wr), 0);
    end
    p_wr(8'hD9);
    chk("R1 write wrap 15->0 tk_wr", int'(s_wr), 1);
    chk("R1 write wrap sel 0", int'(s_sel), 0);
    chk("R5 sec mask", int'(s_data), 'h59);
    p_stop;
    p_start_rd;
    p_rd(rv); chk("R3 first read is reg15", rv, ((15 * 17) ^ 'h5A) & 'hFF);
    for (int p = 0; p < 7; p++) p_rd(rv);
    for (int p = 7; p < 16; p++) begin
      p_rd(rv); chk("R4 stored readback", rv, ((p * 17) ^ 'h5A) & 'hFF);
    end
    p_rd(rv); chk("R1 read wrap 15->0 (sec snapshot)", rv, 0);
    p_stop;

    // STOP cancels pending address
    p_start_wr; p_wr(8'h90); p_stop;
    p_start_wr; p_stop;
    p_wr(8'h3C);
    chk("R11 byte after STOP is data, no tk", int'(s_wr), 0);
    chk("R11 fmt kept", int'(fmt), 0);
    p_start_wr; p_wr(8'h90); p_stop;
    p_rd(rv); chk("R11 data stored at reg9", rv, 'h3C);

    // masks in 24h mode
    set_reg(8'h0F, 8'h20);
    p_start_wr; p_wr(8'h00);
    for (int p = 0; p < 7; p++) begin
      p_wr(8'hFF);
      if (p == 3) chk("R8 weekday no tk", int'(s_wr), 0);
      else begin
        chk("R4 tk_wr", int'(s_wr), 1);
        chk("R4 tk_sel", int'(s_sel), p);
        case (p)
          0, 1: chk("R5 mask 7F", int'(s_data), 'h7F);
          2, 4: chk("R5 mask 3F", int'(s_data), 'h3F);
          5: chk("R5 mask 1F", int'(s_data), 'h1F);
          default: chk("R5 year full", int'(s_data), 'hFF);
        endcase
      end
    end
    p_stop;

    // 12h hour write sweep
    set_reg(8'h0F, 8'h00);
    for (int pm = 0; pm < 2; pm++)
      for (int h = 1; h <= 12; h++) begin
        int t;
        t = h + 12 * pm;
        if (t == 12 || t == 24) t -= 12;
        p_start_wr; p_wr(8'h20); p_wr(8'((pm << 5)) | bcd(h)); p_stop;
        chk("R7 hour write strobe", int'(s_wr), 1);
        chk("R7 hour 12->24", int'(s_data), int'(bcd(t)));
      end

    // hour snapshot sweep, both modes, plus other fields
    l_sec = 8'h42; l_min = 8'h17; l_mday = 8'h28; l_mon = 8'h11; l_year = 8'h93;
    for (int m = 0; m < 2; m++) begin
      set_reg(8'h0F, m ? 8'h20 : 8'h00);
      for (int h = 0; h < 24; h++) begin
        int e;
        logic [7:0] ex;
        l_hour = bcd(h);
        p_start_rd;
        p_rd(rv); chk("R3 ctrl first", rv, m ? 'h20 : 0);
        p_rd(rv); chk("R3 sec snapshot", rv, 'h42);
        p_rd(rv); chk("R3 min snapshot", rv, 'h17);
        p_rd(rv);
        if (m) ex = bcd(h);
        else begin
          e = (h % 12 == 0) ? h + 12 : h;
          ex = (e <= 12) ? bcd(e) : (8'h20 | bcd(e - 12));
        end
        chk("R6 hour snapshot", rv, ex);
        p_rd(rv); p_rd(rv); chk("R3 mday snapshot", rv, 'h28);
        p_rd(rv); chk("R3 mon snapshot", rv, 'h11);
        p_rd(rv); chk("R3 year snapshot", rv, 'h93);
        p_stop;
      end
    end

    // snapshot freezes: live change does not alter registers until next read START
    l_sec = 8'h05;
    p_start_wr; p_wr(8'h00); p_stop;
    p_rd(rv); chk("R3 shadow held until read START", rv, 'h42);

    // weekday offset sweep
    for (int u = 0; u < 8; u++)
      for (int w = 0; w < 7; w++) begin
        l_wday = 3'(w);
        p_start_wr; p_wr(8'h30); p_wr(8'(u));
        chk("R8 weekday write no tk", int'(s_wr), 0);
        p_stop;
        l_wday = 3'((w + 3) % 7);
        p_start_rd;
        for (int k = 0; k < 4; k++) p_rd(rv);
        p_rd(rv); chk("R8 weekday snapshot", rv, ((u + 6 + 3) % 7) + 1);
        p_stop;
      end

    // reset clears storage and weekday offset
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1; @(negedge clk);
    l_wday = 3'd2;
    p_start_rd;
    p_rd(rv); chk("R9 ctrl cleared", rv, 0);
    for (int k = 0; k < 3; k++) p_rd(rv);
    p_rd(rv); chk("R9 weekday offset cleared", rv, 3);
    for (int k = 4; k < 9; k++) p_rd(rv);
    p_rd(rv); chk("R9 reg9 cleared", rv, 0);
    p_stop;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule